// File: doc/BRIEF.md
# Register-Mapped Bidirectional I/O Port

This block is a parallel input/output port of configurable width (eight pins by default) that sits in a processor's register file. Software reaches it through a simple single-cycle register bus. Each pin has its own direction bit. A direction bit of 1 leaves the pin floating as an input. A direction bit of 0 drives the pin from an output latch. The pad ring receives an output-enable vector and an output-value vector, and returns the sampled pin levels.

Writing the data register changes only the output latch. Reading the data register returns the levels seen on the pins, after a two-flop synchroniser, and not the latch. Two write-only strobe registers set or clear chosen latch bits without disturbing the others. These updates act on the latch, so a pin that is currently an input keeps the value it will drive once it is switched to an output.

Top module: `gpio_port`

## Requirements
- R1: While reset is high, and after it, every direction bit is 1 and the latch is 0. This means `pin_oe` = 0, `pin_out` = 0, and a read of the direction offset returns all ones.
- R2: `pin_oe[i]` is the inverse of direction bit i. For example, direction 0xCF gives `pin_oe` = 0x30, which drives bits 5:4 and leaves bits 7:6 and 3:0 as inputs.
- R3: A write (`bus_sel`=1, `bus_wr`=1) to the data offset 0x1 loads `bus_wdata` into the latch. `pin_out` shows the new value from the next cycle on. The direction bits do not change.
- R4: A read of the data offset returns the pin levels through two flip-flop stages. A change on `pin_in` before clock edge k is returned after edge k+1 and not before. The synchroniser stages reset to 0.
- R5: A write to the set offset 0x2 sets each latch bit whose `bus_wdata` bit is 1 and leaves every other bit unchanged.
- R6: A write to the clear offset 0x3 clears each latch bit whose `bus_wdata` bit is 1 and leaves every other bit unchanged.
- R7: Set and clear act on the latch and not on the pin levels. A bit configured as input keeps the latch value it was given, and that value appears on `pin_out` once the bit is made an output.
- R8: A write to the direction offset 0x0 loads the direction bits, and a read of that offset returns them.
- R9: The following have no effect on `pin_out` or `pin_oe`: a cycle with `bus_sel` low, a cycle with `bus_wr` low, and a write to any offset other than 0x0 to 0x3. `bus_rdata` is 0 when `bus_sel` is low, and it is also 0 for the offsets 0x2, 0x3 and any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_wdata | input | WIDTH (8) | Write data or bit mask |
| bus_rdata | output | WIDTH (8) | Combinational read data |
| pin_in | input | WIDTH (8) | Levels sampled at the pads |
| pin_oe | output | WIDTH (8) | Per-pin drive enable, 1 = drive |
| pin_out | output | WIDTH (8) | Per-pin driven value (output latch) |

## Verification
There is one bus access per cycle, so the read of the data offset is combinational and falls in the same cycle as a write to that same offset. In that cycle the output latch is being loaded while the data path returns pin levels. The bench provokes this case directly, with a latch value that differs from the pins. It also provokes it many times at random, with `pin_in` changing on the same cycles. The read is judged against a bench model of the two-stage pin pipeline and never against the latch, and `pin_out` is judged one cycle later against the written value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Default register offsets; the bus layout depends on these
    localparam int unsigned OFS_DIR  = 0;
    localparam int unsigned OFS_DATA = 1;
    localparam int unsigned OFS_SET  = 2;
    localparam int unsigned OFS_CLR  = 3;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_DIR  = 3'd1,
        TGT_DATA = 3'd2,
        TGT_SET  = 3'd3,
        TGT_CLR  = 3'd4
    } gpio_tgt_e;

    typedef struct packed {
        logic      write;
        logic      read;
        gpio_tgt_e target;
    } gpio_req_t;

    // Next value of one latch bit for a given write target
    function automatic logic latch_next(gpio_tgt_e tgt, logic cur, logic wbit);
        logic nxt;
        nxt = cur;
        case (tgt)
            TGT_DATA: nxt = wbit;
            TGT_SET:  nxt = cur | wbit;
            TGT_CLR:  nxt = cur & ~wbit;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DIR_OFS  = OFS_DIR,
    parameter int unsigned DATA_OFS = OFS_DATA,
    parameter int unsigned SET_OFS  = OFS_SET,
    parameter int unsigned CLR_OFS  = OFS_CLR
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output gpio_req_t         req
);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_OFS);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_OFS);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);

    gpio_tgt_e tgt;

    always_comb begin
        if (addr == A_DIR)       tgt = TGT_DIR;
        else if (addr == A_DATA) tgt = TGT_DATA;
        else if (addr == A_SET)  tgt = TGT_SET;
        else if (addr == A_CLR)  tgt = TGT_CLR;
        else                     tgt = TGT_NONE;
    end

    always_comb begin
        req.write  = sel & wr & (tgt != TGT_NONE);
        req.read   = sel & ~wr;
        req.target = sel ? tgt : TGT_NONE;
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= '0;
                else     stage[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  gpio_req_t        req,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic dir_b;
        logic lat_b;

        always_ff @(posedge clk) begin
            if (rst) begin
                dir_b <= 1'b1;
                lat_b <= 1'b0;
            end else if (req.write) begin
                if (req.target == TGT_DIR) dir_b <= wdata[i];
                lat_b <= latch_next(req.target, lat_b, wdata[i]);
            end
        end

        assign dir_q[i] = dir_b;
        assign lat_q[i] = lat_b;
    end
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  gpio_req_t        req,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] rdata
);
    always_comb begin
        case (req.target)
            TGT_DIR:  rdata = dir_q;
            TGT_DATA: rdata = pins_sync;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DIR_OFS     = OFS_DIR,
    parameter int unsigned DATA_OFS    = OFS_DATA,
    parameter int unsigned SET_OFS     = OFS_SET,
    parameter int unsigned CLR_OFS     = OFS_CLR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out
);
    gpio_req_t        req;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] pins_sync;

    gpio_decode #(
        .ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS), .DATA_OFS(DATA_OFS),
        .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
    ) u_dec (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .req(req)
    );

    gpio_bank #(.WIDTH(WIDTH)) u_bank (
        .clk(clk), .rst(rst), .req(req), .wdata(bus_wdata),
        .dir_q(dir_q), .lat_q(lat_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(pin_in), .dout(pins_sync)
    );

    gpio_readmux #(.WIDTH(WIDTH)) u_rmux (
        .req(req), .dir_q(dir_q), .pins_sync(pins_sync), .rdata(bus_rdata)
    );

    assign pin_oe  = ~dir_q;
    assign pin_out = lat_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DIR_OFS  = 0,
    parameter int unsigned DATA_OFS = 1,
    parameter int unsigned SET_OFS  = 2,
    parameter int unsigned CLR_OFS  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pin_in,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_out
);
    logic [1:0] age;
    logic       wr_any;
    logic       mapped;

    always_ff @(posedge clk) begin
        if (rst)            age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    assign wr_any = bus_sel & bus_wr;
    assign mapped = (bus_addr == ADDR_W'(DIR_OFS))  || (bus_addr == ADDR_W'(DATA_OFS)) ||
                    (bus_addr == ADDR_W'(SET_OFS))  || (bus_addr == ADDR_W'(CLR_OFS));

    // R2, R8: drive enable is the inverse of the direction read back
    a_r2_oe_inverse_dir: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr == ADDR_W'(DIR_OFS)) |-> (pin_oe == ~bus_rdata));

    a_r3_data_write: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr == ADDR_W'(DATA_OFS)) |=>
            (pin_out == $past(bus_wdata) && $stable(pin_oe)));

    a_r4_sync_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && bus_sel && bus_addr == ADDR_W'(DATA_OFS)) |->
            (bus_rdata == $past(pin_in, 2)));

    a_r5_set_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr == ADDR_W'(SET_OFS)) |=>
            (pin_out == ($past(pin_out) | $past(bus_wdata))));

    a_r6_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr == ADDR_W'(CLR_OFS)) |=>
            (pin_out == ($past(pin_out) & ~$past(bus_wdata))));

    a_r9_no_effect: assert property (@(posedge clk) disable iff (rst)
        (!wr_any || !mapped) |=> ($stable(pin_out) && $stable(pin_oe)));

    a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel) |-> (bus_rdata == '0));
endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS), .DATA_OFS(DATA_OFS),
    .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    logic [7:0] e_dir = 8'hFF;
    logic [7:0] e_lat = 8'h00;
    logic [7:0] m1 = 8'h00;
    logic [7:0] m2 = 8'h00;

    always #4 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // R4 model: two pipeline stages, cleared by reset
    always @(posedge clk) begin
        if (rst) begin m1 <= 8'h00; m2 <= 8'h00; end
        else     begin m1 <= pin_in; m2 <= m1; end
    end

    function automatic logic [7:0] exp_read(bit sel, logic [3:0] a);
        if (!sel)           return 8'h00;
        else if (a == 4'd0) return e_dir;
        else if (a == 4'd1) return m2;
        else                return 8'h00;
    endfunction

    function automatic logic [7:0] next_lat(logic [3:0] a, logic [7:0] cur, logic [7:0] d);
        case (a)
            4'd1:    return d;
            4'd2:    return cur | d;
            4'd3:    return cur & ~d;
            default: return cur;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // One bus cycle: check outputs, drive, check the read, commit and update the model
    task automatic op(bit sel, bit wr, logic [3:0] a, logic [7:0] d, logic [7:0] pins);
        @(negedge clk);
        chk("R2 pin_oe", pin_oe, ~e_dir);
        chk("R3 pin_out", pin_out, e_lat);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; pin_in = pins;
        #1;
        if (!sel || a > 4'd1) chk("R9 rdata", bus_rdata, exp_read(sel, a));
        else if (a == 4'd0)   chk("R8 rdata", bus_rdata, exp_read(sel, a));
        else                  chk("R4 rdata", bus_rdata, exp_read(sel, a));
        @(posedge clk);
        #1;
        if (sel && wr) begin
            if (a == 4'd0) e_dir = d;
            e_lat = next_lat(a, e_lat, d);
        end
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        pin_in = 8'h3C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state held during reset
        chk("R1 pin_oe in reset", pin_oe, 8'h00);
        chk("R1 pin_out in reset", pin_out, 8'h00);
        rst = 1'b0;
        // R1: direction reads as all ones after reset
        op(1, 0, 4'd0, 8'h00, 8'h3C);
        @(negedge clk); bus_sel = 1; bus_addr = 4'd0; #1;
        chk("R1 dir readback", bus_rdata, 8'hFF);
        bus_sel = 0;
        // R2: 0xCF leaves bits 5:4 driven
        op(1, 1, 4'd0, 8'hCF, 8'h3C);
        @(negedge clk);
        chk("R2 oe for CF", pin_oe, 8'h30);
        // R3/R4: write data while reading it in the same cycle
        op(1, 0, 4'd1, 8'h00, 8'h3C);
        op(1, 1, 4'd1, 8'hA5, 8'h3C);
        @(negedge clk);
        chk("R3 latch loaded", pin_out, 8'hA5);
        bus_sel = 1; bus_addr = 4'd1; #1;
        chk("R3 read gives pins not latch", bus_rdata, 8'h3C);
        bus_sel = 0;
        // R5/R6/R7: set and clear on latch bits, some of them inputs
        op(1, 1, 4'd2, 8'h42, 8'h3C);
        @(negedge clk);
        chk("R5 set", pin_out, 8'hE7);
        op(1, 1, 4'd3, 8'h81, 8'h3C);
        @(negedge clk);
        chk("R6 clear", pin_out, 8'h66);
        op(1, 1, 4'd0, 8'h00, 8'h3C);
        @(negedge clk);
        chk("R7 input-bit latch appears", pin_out & pin_oe, 8'h66);
        // R9: ignored writes
        op(1, 1, 4'd5, 8'hFF, 8'h3C);
        op(0, 1, 4'd1, 8'h00, 8'h3C);
        op(1, 0, 4'd0, 8'hFF, 8'h3C);
        @(negedge clk);
        chk("R9 unmapped/idle/read writes ignored", pin_out, 8'h66);
        chk("R9 direction unchanged", pin_oe, 8'hFF);
        // R4 latency: new pins after two edges, not one
        op(1, 0, 4'd1, 8'h00, 8'h00);
        op(1, 0, 4'd1, 8'h00, 8'h00);
        op(1, 0, 4'd1, 8'h00, 8'h00);
        op(1, 0, 4'd1, 8'h00, 8'hC3);
        @(negedge clk); bus_sel = 1; bus_addr = 4'd1; #1;
        chk("R4 one edge: old level", bus_rdata, 8'h00);
        @(negedge clk); #1;
        chk("R4 two edges: new level", bus_rdata, 8'hC3);
        bus_sel = 0;
        // Random mix; writes to data fall together with pin changes
        for (int n = 0; n < 400; n++) begin
            logic [7:0] pins;
            pins = ($urandom % 3 == 0) ? 8'($urandom) : pin_in;
            op(($urandom % 5) != 0, ($urandom % 2) != 0, 4'($urandom % 6), 8'($urandom), pins);
        end
        @(negedge clk);
        chk("R2 final oe", pin_oe, ~e_dir);
        chk("R3 final out", pin_out, e_lat);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule